// File: doc/BRIEF.md
# Indexed Interrupt Routing Register File

This block holds the programmable state of an interrupt router behind a narrow two-location bus footprint. A bus master first writes a register index into a select location, then reads or writes the selected register through a data window. Behind the window sit an identification register, a fixed version word, an arbitration word that mirrors the identification value, and a table of redirection entries. Each entry is 64 bits wide and spans two consecutive indices, one per 32-bit half.

The full redirection table is also exported as a flat vector, so that a separate delivery unit can read every entry's routing fields without going through the bus. Every entry comes out of reset masked, so nothing is routed until software programs the table. Bus reads return their data one clock after the read request.

Top module: `irq_redir_regs`

## Requirements
- R1: Only accesses with `bus_size` = 4 at byte offset 0x00 (select) or 0x10 (window) have any effect. A write with another size or offset changes no state: select, identification and table all stay as they were.
- R2: A read with a size other than 4, or at an offset other than 0x00 or 0x10, returns zero.
- R3: A read at offset 0x00 returns the full 32-bit select value last written. A window access uses only select bits 7:0 as the register index.
- R4: Index 0 is the identification register. A window write stores only data bits 31:24 and clears bits 23:0. A window read returns the stored value.
- R5: Index 1 reads 0x00100011: the entry count (16) in bits 23:16 and 0x11 in bits 7:0. A write to it has no effect.
- R6: Index 2 reads the same value as the identification register. A write to it has no effect.
- R7: Entry n (0 to 15) is reached at index 0x10+2n for bits 31:0 and at index 0x11+2n for bits 63:32.
- R8: A window write to a table index replaces only the addressed 32-bit half and leaves the other half of that entry unchanged.
- R9: After reset the select and identification registers are zero, and every table entry is 0x0001000000010000.
- R10: Indices 3 to 0x0F and 0x30 to 0xFF read zero. Writes to them change nothing.
- R11: `redir_table[64n+63:64n]` holds entry n. It shows a table write from the clock edge that performs the write.
- R12: `bus_rdata` is updated at the clock edge that samples `bus_rd` high and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_off | input | 8 | Byte offset of the access |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after `bus_rd` |
| redir_table | output | 1024 | All redirection entries, entry n at bits 64n+63:64n |

## Verification
The bench sweeps the window over all 256 index values in several states: after reset, after a distinct pattern has been written into every table half, and after writes to every unimplemented and read-only index. Each sweep separates correct index decoding and half selection from aliasing between entries or halves. Bad sizes and stray offsets are tried against both select and window, which shows whether the access gate is complete. Select values with upper bits set, and a single-half write, show that only the low index byte decodes and that the untouched half survives.

// File: rtl/irq_redir_regs.sv
module irq_redir_regs #(
  parameter int          NUM_ENTRIES = 16,
  parameter logic [31:0] ID_MASK     = 32'hFF00_0000,
  parameter logic [7:0]  VER_CODE    = 8'h11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [7:0]                bus_off,
  input  logic [3:0]                bus_size,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [64*NUM_ENTRIES-1:0] redir_table
);

  localparam int          TBL_BASE  = 16;
  localparam logic [7:0]  OFF_SEL   = 8'h00;
  localparam logic [7:0]  OFF_WIN   = 8'h10;
  localparam logic [63:0] ENTRY_RST = 64'h0001_0000_0001_0000;
  localparam logic [31:0] VER_VAL   = {8'h00, 8'(NUM_ENTRIES), 8'h00, VER_CODE};

  logic [31:0] sel_q;
  logic [31:0] id_q;
  logic [31:0] win_val;
  logic [63:0] tbl_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hit_lo, hit_hi;

  wire        size_ok = (bus_size == 4'd4);
  wire        sel_acc = size_ok && (bus_off == OFF_SEL);
  wire        win_acc = size_ok && (bus_off == OFF_WIN);
  wire        win_wr  = bus_wr && win_acc;
  wire [7:0]  idx     = sel_q[7:0];
  wire        is_tbl  = |{hit_lo, hit_hi};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                sel_q <= '0;
    else if (bus_wr && sel_acc) sel_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     id_q <= '0;
    else if (win_wr && idx == 8'd0) id_q <= bus_wdata & ID_MASK;

  genvar e;
  generate
    for (e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      assign hit_lo[e] = (idx == 8'(TBL_BASE + 2*e));
      assign hit_hi[e] = (idx == 8'(TBL_BASE + 2*e + 1));

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) tbl_q[e] <= ENTRY_RST;
        else if (win_wr && hit_lo[e]) tbl_q[e][31:0]  <= bus_wdata;
        else if (win_wr && hit_hi[e]) tbl_q[e][63:32] <= bus_wdata;

      assign redir_table[64*e +: 64] = tbl_q[e];

      assert_keep_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && hit_lo[e]) |=> (tbl_q[e][63:32] == $past(tbl_q[e][63:32])));
      assert_keep_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && hit_hi[e]) |=> (tbl_q[e][31:0] == $past(tbl_q[e][31:0])));
      assert_bad_wr_tbl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !sel_acc && !win_acc) |=> $stable(tbl_q[e]));
    end
  endgenerate

  always_comb begin
    win_val = '0;
    case (idx)
      8'd0:    win_val = id_q;
      8'd1:    win_val = VER_VAL;
      8'd2:    win_val = id_q;
      default: begin
        for (int n = 0; n < NUM_ENTRIES; n++) begin
          if (hit_lo[n]) win_val = tbl_q[n][31:0];
          if (hit_hi[n]) win_val = tbl_q[n][63:32];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= sel_acc ? sel_q : (win_acc ? win_val : 32'd0);

  assert_bad_rd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !sel_acc && !win_acc) |=> (bus_rdata == 32'd0));
  assert_sel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && sel_acc)) |=> $stable(sel_q));
  assert_ver_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && (idx == 8'd1 || idx == 8'd2)) |=> $stable(id_q));
  assert_ver_val_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && win_acc && idx == 8'd1) |=> (bus_rdata == VER_VAL));
  assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && win_acc && idx > 8'd2 && !is_tbl) |=> (bus_rdata == 32'd0));
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |=> $stable(bus_rdata));

endmodule

// File: tb/irq_redir_regs_tb.sv
module irq_redir_regs_tb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_off = '0;
  logic [3:0] bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [64*N-1:0] redir_table;

  irq_redir_regs #(.NUM_ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_off(bus_off), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .redir_table(redir_table));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [63:0] m_tbl [N];
  logic [31:0] m_sel, m_id;
  logic [31:0] rd;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [3:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_off = off; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (sz == 4'd4 && off == 8'h00) m_sel = d;
    else if (sz == 4'd4 && off == 8'h10) begin
      if (m_sel[7:0] == 8'd0) m_id = d & 32'hFF00_0000;
      else if (m_sel[7:0] >= 8'h10 && m_sel[7:0] < 8'h30) begin
        if (m_sel[0]) m_tbl[(m_sel[7:0]-8'h10)/2][63:32] = d;
        else          m_tbl[(m_sel[7:0]-8'h10)/2][31:0]  = d;
      end
    end
  endtask

  task automatic rdb(input logic [7:0] off, input logic [3:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_off = off; bus_size = sz;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_win(input logic [7:0] i);
    if (i == 8'd0 || i == 8'd2) return m_id;
    if (i == 8'd1) return 32'h0010_0011;
    if (i >= 8'h10 && i < 8'h30)
      return i[0] ? m_tbl[(i-8'h10)/2][63:32] : m_tbl[(i-8'h10)/2][31:0];
    return 32'd0;
  endfunction

  task automatic sweep(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 256; i++) begin
      wr(8'h00, 4'd4, 32'(i));
      rdb(8'h10, 4'd4, v);
      check($sformatf("%s idx=%0h", tag, i), {32'd0, v}, {32'd0, exp_win(8'(i))});
    end
  endtask

  task automatic check_export(input string tag);
    for (int n = 0; n < N; n++)
      check($sformatf("%s entry %0d", tag, n), redir_table[64*n +: 64], m_tbl[n]);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < N; n++) m_tbl[n] = 64'h0001_0000_0001_0000;
    m_sel = '0; m_id = '0;
    #23 rst_n = 1'b1;

    check_export("R9 reset export R11");
    rdb(8'h00, 4'd4, rd);
    check("R9 reset select", {32'd0, rd}, 64'd0);
    sweep("R9 R7 R5 R6 R10 reset sweep");

    for (int i = 0; i < 2*N; i++) begin
      wr(8'h00, 4'd4, 32'h10 + 32'(i));
      wr(8'h10, 4'd4, (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0F96);
      check_export("R11 R7 after table write");
    end
    sweep("R7 pattern sweep");

    wr(8'h00, 4'd4, 32'h16);
    wr(8'h10, 4'd4, 32'h1234_5678);
    check("R8 low write keeps high", redir_table[64*3 +: 64], m_tbl[3]);
    wr(8'h00, 4'd4, 32'h19);
    wr(8'h10, 4'd4, 32'hCAFE_F00D);
    check("R8 high write keeps low", redir_table[64*4 +: 64], m_tbl[4]);

    wr(8'h00, 4'd4, 32'h0);
    wr(8'h10, 4'd4, 32'hFFFF_FFFF);
    rdb(8'h10, 4'd4, rd);
    check("R4 id mask", {32'd0, rd}, 64'hFF00_0000);
    wr(8'h00, 4'd4, 32'h2);
    rdb(8'h10, 4'd4, rd);
    check("R6 arb mirrors id", {32'd0, rd}, 64'hFF00_0000);
    wr(8'h10, 4'd4, 32'h1100_0000);
    wr(8'h00, 4'd4, 32'h1);
    wr(8'h10, 4'd4, 32'h2200_0000);
    rdb(8'h10, 4'd4, rd);
    check("R5 version fixed", {32'd0, rd}, 64'h0010_0011);
    wr(8'h00, 4'd4, 32'h0);
    rdb(8'h10, 4'd4, rd);
    check("R5 R6 id unchanged by ro writes", {32'd0, rd}, 64'hFF00_0000);

    for (int i = 3; i < 256; i++) begin
      if (i >= 16 && i < 48) continue;
      wr(8'h00, 4'd4, 32'(i));
      wr(8'h10, 4'd4, 32'hDEAD_0000 | 32'(i));
    end
    sweep("R10 after unimplemented writes");
    check_export("R10 export unchanged");

    wr(8'h00, 4'd4, 32'h12);
    for (int s = 0; s < 16; s++) begin
      if (s == 4) continue;
      wr(8'h10, 4'(s), 32'h0BAD_0BAD);
      wr(8'h00, 4'(s), 32'h0000_0001);
    end
    begin
      logic [7:0] offs [6] = '{8'h04, 8'h08, 8'h0C, 8'h14, 8'h11, 8'h80};
      foreach (offs[k]) wr(offs[k], 4'd4, 32'h0BAD_0BAD);
      foreach (offs[k]) begin
        rdb(offs[k], 4'd4, rd);
        check("R2 stray offset read", {32'd0, rd}, 64'd0);
      end
    end
    rdb(8'h00, 4'd4, rd);
    check("R1 select unchanged", {32'd0, rd}, 64'h12);
    check_export("R1 export after bad writes");
    rdb(8'h10, 4'd2, rd);
    check("R2 bad size window read", {32'd0, rd}, 64'd0);
    rdb(8'h00, 4'd8, rd);
    check("R2 bad size select read", {32'd0, rd}, 64'd0);

    wr(8'h00, 4'd4, 32'hABCD_0112);
    rdb(8'h00, 4'd4, rd);
    check("R3 select readback", {32'd0, rd}, 64'hABCD_0112);
    rdb(8'h10, 4'd4, rd);
    check("R3 low byte index", {32'd0, rd}, {32'd0, m_tbl[1][31:0]});
    @(negedge clk);
    bus_off = 8'h00;
    @(negedge clk);
    check("R12 rdata holds", {32'd0, bus_rdata}, {32'd0, m_tbl[1][31:0]});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule